// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block gives a processor three byte-wide general-purpose ports, called A, B and C, behind a small strobed bus. Each port can be set up as an input or as an output. Port C is handled as two nibbles that can be set up separately. The processor reaches the block through an active-low chip select, active-low read and write strobes, a 2-bit select that picks a port or the control register, and a byte-wide data bus. The block drives that data bus only while a read is in progress.

One control address takes two kinds of word. If bit 7 of the word is 1, it is a configuration word: it sets the directions and clears to zero every output latch whose port ends up as an output. If bit 7 is 0, the word sets or clears one chosen bit of the port C latch and leaves everything else as it was. Output data sits in latches. Inputs are not latched, so reading an input port returns the live pin levels. Each port has separate pin-in, pin-out and per-bit drive-enable signals, so the pads can sit outside the core. The group mode fields are stored and can be read back, but the ports always run as plain unhandshaked ports.

The write strobe is asynchronous to the core clock. A write takes effect on the rising edge of the strobe, once that edge has passed through the synchroniser. Reads are combinational from the strobes to the data bus.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset the control register reads 0x9B. Every drive-enable is low and every output latch holds zero.
- R2: The select value chooses what a read returns: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. `dout_oe` is high exactly while `cs_n` and `rd_n` are both low.
- R3: A write strobe given while `cs_n` is high changes neither the control register nor any latch.
- R4: In a configuration word (bit 7 = 1), the direction bits are: bit 4 for port A, bit 3 for the upper nibble of port C, bit 1 for port B and bit 0 for the lower nibble of port C. A direction bit of 1 means input. Each drive-enable bit is high exactly when its port or nibble is an output. Reading the control address returns the word that was written.
- R5: A configuration word clears to zero the latch of every port or port C nibble that it makes an output. It keeps the latch of every port or nibble that it makes an input.
- R6: Reading a port that is an output returns its latch. Reading a port that is an input returns its `*_in` pins.
- R7: The two nibbles of port C follow their own direction bits on the drive-enables, on reads and on clearing.
- R8: A word with bit 7 = 0 written to the control address loads bit 0 into the port C latch bit chosen by bits 3:1. All other port C bits and the control register stay unchanged.
- R9: A write to a port that is set as input updates its latch but does not drive the pins. The drive-enables stay low and the pins keep their external level.
- R10: The group mode fields (bits 6:5 and bit 2) are stored and read back, but the ports keep behaving as plain unhandshaked ports.
- R11: A write takes effect on the rising edge of `wr_n`. The new state is visible after the third rising clock edge that follows that strobe edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 2 | Port or control select |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus |
| dout_oe | output | 1 | Bus drive enable for read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit drive enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit drive enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit drive enable |

## Verification
Reads involve no register, so the bench samples `dout` and `dout_oe` one time step after it lowers the strobes, in the same clock low phase. A write goes through two synchroniser flops and one edge-detect flop before it commits. The bench therefore waits four clock edges after raising `wr_n` before it reads back or compares latches and drive-enables. For R11, one directed case samples `pa_out` after the second edge and again after the third, to confirm that the commit lands on the third edge.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    localparam int DW       = 8;
    localparam int AW       = 2;
    localparam int NPORTS   = 3;
    localparam int IDXW     = $clog2(DW);
    localparam int HALF     = DW / 2;
    localparam logic [DW-1:0] CTRL_RESET = 8'h9B;

    typedef enum logic [AW-1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    typedef struct packed {
        logic       is_cfg;
        logic [1:0] grp_a_mode;
        logic       a_in;
        logic       cu_in;
        logic       grp_b_mode;
        logic       b_in;
        logic       cl_in;
    } cfg_word_t;

    // Per-bit input mask of one port under a given configuration
    function automatic logic [DW-1:0] in_mask(input cfg_word_t c, input int p);
        logic [DW-1:0] m;
        case (p)
            0:       m = {DW{c.a_in}};
            1:       m = {DW{c.b_in}};
            default: m = {{HALF{c.cu_in}}, {HALF{c.cl_in}}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ppio_bus_if.sv
module ppio_bus_if
    import ppio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    logic [SYNC_STAGES:0] wr_sync;
    logic                 wr_level;
    logic                 wr_prev;
    logic                 hold_cs;

    always_ff @(posedge clk) begin
        if (rst) wr_sync <= '1;
        else     wr_sync <= {wr_sync[SYNC_STAGES-1:0], wr_n};
    end

    assign wr_level = wr_sync[SYNC_STAGES-1];
    assign wr_prev  = wr_sync[SYNC_STAGES];

    // Address, data and select are sampled while the strobe is seen low
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cs <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (!wr_level) begin
            hold_cs <= ~cs_n;
            wr_addr <= addr;
            wr_data <= din;
        end
    end

    assign wr_pulse = wr_level & ~wr_prev & hold_cs;

endmodule

// File: rtl/ppio_cfg.sv
module ppio_cfg
    import ppio_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_pulse,
    input  logic [AW-1:0]              wr_addr,
    input  logic [DW-1:0]              wr_data,
    output cfg_word_t                  ctrl_q,
    output logic [NPORTS-1:0]          port_wr,
    output logic [NPORTS-1:0][DW-1:0]  clr_mask,
    output logic                       bit_wr,
    output logic [IDXW-1:0]            bit_idx,
    output logic                       bit_val
);
    cfg_word_t word;
    logic      to_ctrl;
    logic      cfg_wr;

    assign word    = cfg_word_t'(wr_data);
    assign to_ctrl = wr_pulse && (sel_e'(wr_addr) == SEL_CTRL);
    assign cfg_wr  = to_ctrl && word.is_cfg;
    assign bit_wr  = to_ctrl && !word.is_cfg;
    assign bit_idx = wr_data[IDXW:1];
    assign bit_val = wr_data[0];

    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= cfg_word_t'(CTRL_RESET);
        else if (cfg_wr) ctrl_q <= word;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_dec
        assign port_wr[p]  = wr_pulse && (wr_addr == AW'(p));
        assign clr_mask[p] = {DW{cfg_wr}} & ~in_mask(word, p);
    end

endmodule

// File: rtl/ppio_port_latch.sv
module ppio_port_latch
    import ppio_pkg::*;
#(
    parameter bit HAS_BITOP = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_val,
    input  logic [DW-1:0]   clr,
    input  logic            bit_wr,
    input  logic [IDXW-1:0] bit_idx,
    input  logic            bit_val,
    output logic [DW-1:0]   q
);
    logic [DW-1:0] nxt;

    always_comb begin
        nxt = q;
        if (wr_en) begin
            nxt = wr_val;
        end else if (|clr) begin
            nxt = q & ~clr;
        end else if (HAS_BITOP && bit_wr) begin
            nxt[bit_idx] = bit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
    import ppio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    logic                      wr_pulse;
    logic [AW-1:0]             wr_addr;
    logic [DW-1:0]             wr_data;
    cfg_word_t                 ctrl_q;
    logic [NPORTS-1:0]         port_wr;
    logic [NPORTS-1:0][DW-1:0] clr_mask;
    logic                      bit_wr;
    logic [IDXW-1:0]           bit_idx;
    logic                      bit_val;
    logic [NPORTS-1:0][DW-1:0] pin_in;
    logic [NPORTS-1:0][DW-1:0] latch_q;
    logic [NPORTS-1:0][DW-1:0] drive;
    logic [NPORTS-1:0][DW-1:0] rd_val;

    ppio_bus_if #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .din      (din),
        .wr_pulse (wr_pulse),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    ppio_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_pulse (wr_pulse),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl_q   (ctrl_q),
        .port_wr  (port_wr),
        .clr_mask (clr_mask),
        .bit_wr   (bit_wr),
        .bit_idx  (bit_idx),
        .bit_val  (bit_val)
    );

    assign pin_in[0] = pa_in;
    assign pin_in[1] = pb_in;
    assign pin_in[2] = pc_in;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        ppio_port_latch #(.HAS_BITOP(p == NPORTS - 1)) u_latch (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (port_wr[p]),
            .wr_val  (wr_data),
            .clr     (clr_mask[p]),
            .bit_wr  (bit_wr),
            .bit_idx (bit_idx),
            .bit_val (bit_val),
            .q       (latch_q[p])
        );
        assign drive[p]  = ~in_mask(ctrl_q, p);
        assign rd_val[p] = (in_mask(ctrl_q, p) & pin_in[p]) | (drive[p] & latch_q[p]);
    end

    assign pa_out = latch_q[0];
    assign pb_out = latch_q[1];
    assign pc_out = latch_q[2];
    assign pa_oe  = drive[0];
    assign pb_oe  = drive[1];
    assign pc_oe  = drive[2];

    assign dout_oe = ~cs_n & ~rd_n;

    always_comb begin
        case (sel_e'(addr))
            SEL_A:    dout = rd_val[0];
            SEL_B:    dout = rd_val[1];
            SEL_C:    dout = rd_val[2];
            default:  dout = DW'(ctrl_q);
        endcase
    end

endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk
    import ppio_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          dout_oe,
    input logic          wr_pulse,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] ctrl_bits,
    input logic [DW-1:0] pa_out,
    input logic [DW-1:0] pc_out
);
    AST_BUS_QUIET_NO_CS: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !dout_oe); // R2

    AST_CTRL_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_pulse |=> $stable(ctrl_bits)); // R11

    AST_CFG_WORD_STORED: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && wr_addr == 2'd3 && wr_data[7]) |=> ctrl_bits == $past(wr_data)); // R4

    AST_CFG_CLEARS_A: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && wr_addr == 2'd3 && wr_data[7] && !wr_data[4]) |=> pa_out == '0); // R5

    AST_BITOP_KEEPS_CTRL: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && wr_addr == 2'd3 && !wr_data[7]) |=> $stable(ctrl_bits)); // R8

    AST_BITOP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && wr_addr == 2'd3 && !wr_data[7]) |=>
            ($countones(pc_out ^ $past(pc_out)) <= 1)); // R8

endmodule

bind ppio_ctrl ppio_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .dout_oe   (dout_oe),
    .wr_pulse  (wr_pulse),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl_bits (DW'(ctrl_q)),
    .pa_out    (pa_out),
    .pc_out    (pc_out)
);

// File: tb/ppio_ctrl_tb.sv
module ppio_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic [7:0] ext_a = 8'h3C, ext_b = 8'hA5, ext_c = 8'h69;
    logic [7:0] pa_pin, pb_pin, pc_pin;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    logic [7:0] m_ctrl = 8'h9B;
    logic [7:0] m_a = '0, m_b = '0, m_c = '0;

    always #4 clk = ~clk; // 125 MHz

    assign pa_pin = (pa_oe & pa_out) | (~pa_oe & ext_a);
    assign pb_pin = (pb_oe & pb_out) | (~pb_oe & ext_b);
    assign pc_pin = (pc_oe & pc_out) | (~pc_oe & ext_c);

    ppio_ctrl dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_pin), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_pin), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_pin), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] oe_of(input int p);
        case (p)
            0:       return {8{~m_ctrl[4]}};
            1:       return {8{~m_ctrl[1]}};
            default: return {{4{~m_ctrl[3]}}, {4{~m_ctrl[0]}}};
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return (oe_of(0) & m_a) | (~oe_of(0) & ext_a);
            2'd1:    return (oe_of(1) & m_b) | (~oe_of(1) & ext_b);
            2'd2:    return (oe_of(2) & m_c) | (~oe_of(2) & ext_c);
            default: return m_ctrl;
        endcase
    endfunction

    task automatic model_wr(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: m_a = d;
            2'd1: m_b = d;
            2'd2: m_c = d;
            default: begin
                if (d[7]) begin
                    m_ctrl = d;
                    if (!d[4]) m_a = '0;
                    if (!d[1]) m_b = '0;
                    if (!d[3]) m_c[7:4] = '0;
                    if (!d[0]) m_c[3:0] = '0;
                end else begin
                    m_c[d[3:1]] = d[0];
                end
            end
        endcase
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit sel = 1);
        @(negedge clk);
        addr = a; din = d; cs_n = ~sel;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        if (sel) model_wr(a, d);
    endtask

    task automatic rd_chk(input logic [1:0] a, input string req);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk(dout_oe === 1'b1, req, "read enable", dout_oe, 1);
        chk(dout === exp_rd(a), req, $sformatf("read sel %0d", a), dout, exp_rd(a));
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic oe_chk(input string req);
        #1;
        chk(pa_oe === oe_of(0), req, "pa_oe", pa_oe, oe_of(0));
        chk(pb_oe === oe_of(1), req, "pb_oe", pb_oe, oe_of(1));
        chk(pc_oe === oe_of(2), req, "pc_oe", pc_oe, oe_of(2));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "WDOG", "timeout", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        process::self().srandom(32'h5EED_1234);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_chk(2'd3, "R1");
        chk(pa_out === 8'h00 && pb_out === 8'h00 && pc_out === 8'h00, "R1", "latches zero",
            {pa_out, pb_out, pc_out}, 0);
        oe_chk("R1");
        rd_chk(2'd0, "R6");

        // R2 bus enable only with both strobes low
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
        chk(dout_oe === 1'b0, "R2", "oe without cs", dout_oe, 0);
        rd_n = 1'b1; cs_n = 1'b0; #1;
        chk(dout_oe === 1'b0, "R2", "oe without rd", dout_oe, 0);
        cs_n = 1'b1;

        // R3 write without chip select ignored
        bus_wr(2'd3, 8'h80, 0);
        rd_chk(2'd3, "R3");
        oe_chk("R3");

        // R4 all outputs, R6 latched data
        bus_wr(2'd3, 8'h80);
        oe_chk("R4");
        bus_wr(2'd0, 8'h5A); bus_wr(2'd1, 8'hC3); bus_wr(2'd2, 8'h96);
        rd_chk(2'd0, "R6"); rd_chk(2'd1, "R6"); rd_chk(2'd2, "R6");
        #1 chk(pa_pin === 8'h5A, "R6", "pin A driven", pa_pin, 8'h5A);

        // R5 configuration word clears outputs, keeps inputs
        bus_wr(2'd3, 8'h82);
        #1 chk(pa_out === 8'h00 && pc_out === 8'h00, "R5", "cleared outputs", {pa_out, pc_out}, 0);
        chk(pb_out === 8'hC3, "R5", "input latch kept", pb_out, 8'hC3);
        rd_chk(2'd1, "R5");
        oe_chk("R5");

        // R7 split port C
        bus_wr(2'd3, 8'h88);
        bus_wr(2'd2, 8'hFF);
        oe_chk("R7");
        rd_chk(2'd2, "R7");
        bus_wr(2'd3, 8'h81);
        rd_chk(2'd2, "R7");

        // R8 single-bit operations
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd3, 8'h0F);
        #1 chk(pc_out === 8'h80, "R8", "set bit 7", pc_out, 8'h80);
        bus_wr(2'd3, 8'h05);
        #1 chk(pc_out === 8'h84, "R8", "set bit 2", pc_out, 8'h84);
        bus_wr(2'd3, 8'h0E);
        #1 chk(pc_out === 8'h04, "R8", "clear bit 7", pc_out, 8'h04);
        rd_chk(2'd3, "R8");

        // R9 write to input port does not drive pins
        bus_wr(2'd3, 8'h9B);
        bus_wr(2'd0, 8'hAA);
        #1 chk(pa_oe === 8'h00, "R9", "no drive", pa_oe, 0);
        chk(pa_pin === ext_a, "R9", "pin kept", pa_pin, ext_a);
        rd_chk(2'd0, "R9");

        // R10 group mode fields stored, basic behaviour
        bus_wr(2'd3, 8'hE4);
        rd_chk(2'd3, "R10");
        bus_wr(2'd0, 8'h77);
        rd_chk(2'd0, "R10");
        oe_chk("R10");

        // R11 commit on third edge after strobe rise
        @(negedge clk); addr = 2'd0; din = 8'h3E; cs_n = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk(pa_out === 8'h77, "R11", "not yet after 2 edges", pa_out, 8'h77);
        @(posedge clk);
        #1 chk(pa_out === 8'h3E, "R11", "committed after 3 edges", pa_out, 8'h3E);
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        model_wr(2'd0, 8'h3E);

        // randomized mix
        for (int i = 0; i < 150; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            ext_a = 8'($urandom); ext_b = 8'($urandom); ext_c = 8'($urandom);
            if (a == 2'd3 && ($urandom_range(0, 3) == 0)) d[7] = 1'b0;
            bus_wr(a, d, ($urandom_range(0, 9) != 0));
            rd_chk(2'($urandom_range(0, 3)), "R6");
            if (i % 10 == 0) begin
                oe_chk("R4");
                rd_chk(2'd3, "R4");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule